// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block takes stereo PCM audio from a three-wire serial link (bit clock, frame clock and a data line) and turns it into parallel 24-bit left and right samples. All three serial lines are sampled by a faster system clock. The block finds the bit-clock edges itself, so the whole design runs in the system clock domain. The system clock must run at least four times faster than the bit clock.

A 2-bit format input selects one of four framing conventions: left-justified, I2S, right-justified or DSP-pulse. A 2-bit length input sets the word length in right-justified framing. Words are left-aligned in the 24-bit outputs. After each complete stereo pair, both outputs are updated together and a one-cycle strobe marks them as new. A change of format restarts the framing from scratch.

Top module: `aud_ser_rx`

## Requirements
- R1: While reset is high and after it is released, `left_sample` and `right_sample` are zero and `pair_valid` is low, until the first pair is delivered.
- R2: With `fmt_sel` = 00 (left-justified), data is captured on rising bit-clock edges. A high frame clock marks the left word and a low frame clock marks the right word. The MSB of a two's complement word, sent MSB first, is the bit captured at the frame-clock transition itself.
- R3: With `fmt_sel` = 01 (I2S), data is captured on rising bit-clock edges. A low frame clock marks left and a high frame clock marks right. The MSB is captured one bit clock after the transition. When a word fills its whole slot, its LSB arrives at the next transition and still belongs to that word.
- R4: With `fmt_sel` = 10 (right-justified), the half-frame is 32 bit clocks and a high frame clock marks left. `rj_len` 00 selects 24 bits, 01 selects 20 bits, 10 selects 16 bits, and 11 is treated as 24 bits. The first data bit is captured 32 minus the length bit clocks after the transition.
- R5: With `fmt_sel` = 11 (DSP), data is captured on falling bit-clock edges. A rising frame-clock pulse precedes each word, and the MSB is the next captured bit. The first pulse after reset or a format change starts a left word, and later pulses alternate strictly between right and left.
- R6: A word shorter than 24 bits is placed MSB-aligned at bit 23, and its unused low bits read zero.
- R7: Bits beyond the 24th in a slot are dropped, and the first 24 bits are kept.
- R8: `pair_valid` is high for exactly one cycle when a left slot begins after a right slot, provided that the left slot of the same pair was received from its start. A pair with a partial left slot produces no strobe.
- R9: `left_sample` and `right_sample` change only together with a `pair_valid` strobe and hold their values otherwise.
- R10: A change of `fmt_sel` discards any pair in progress. No strobe occurs until a full new pair has been framed in the new format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_bclk | input | 1 | Serial bit clock (asynchronous) |
| ser_lrclk | input | 1 | Serial frame clock or frame pulse (asynchronous) |
| ser_data | input | 1 | Serial data line (asynchronous) |
| fmt_sel | input | 2 | Framing: 00 left-justified, 01 I2S, 10 right-justified, 11 DSP |
| rj_len | input | 2 | Right-justified length: 00 24, 01 20, 10 16, 11 24 |
| left_sample | output | 24 | Last complete left word, MSB-aligned |
| right_sample | output | 24 | Last complete right word, MSB-aligned |
| pair_valid | output | 1 | One-cycle strobe when both samples are updated |

## Verification
The bench targets the following corner cases:
- An I2S word that fills its whole slot, where a receiver that starts a new slot too early would lose the LSB and return an even value for 0xFFFFFF.
- The four right-justified length codes, where a wrong start offset shifts the whole word by four or eight places.
- DSP framing with two back-to-back pairs, where a receiver that reads channel from the pulse level or fails to alternate would swap or repeat words.
- A stream that opens mid-pair, and one interrupted by a format change, where a careless design would deliver a strobe carrying a spliced pair.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  typedef enum logic [1:0] {
    FMT_LJ  = 2'b00,
    FMT_I2S = 2'b01,
    FMT_RJ  = 2'b10,
    FMT_DSP = 2'b11
  } fmt_e;

  typedef enum logic {
    CH_L = 1'b0,
    CH_R = 1'b1
  } ch_e;

  // Right-justified word length selected by the length code.
  function automatic int unsigned rj_len_bits(input logic [1:0] code);
    case (code)
      2'b01:   return 20;
      2'b10:   return 16;
      default: return 24;
    endcase
  endfunction

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], async_in[gi]};
      end
      assign sync_out[gi] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/aud_rx_edge.sv
module aud_rx_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise,
  output logic fall
);

  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;

endmodule

// File: rtl/aud_rx_framer.sv
module aud_rx_framer
  import aud_rx_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int SLOT_BITS = 32,
  parameter int CNT_W     = $clog2(SLOT_BITS) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       fmt_sel,
  input  logic [1:0]       rj_len,
  input  logic             cap_rise,
  input  logic             cap_fall,
  input  logic             lr,
  input  logic             dat,
  output logic             wr_en,
  output ch_e              wr_ch,
  output logic [CNT_W-1:0] wr_pos,
  output logic             wr_bit,
  output logic             clr_en,
  output ch_e              clr_ch,
  output logic             emit
);

  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] FULL_LEN = CNT_W'(SAMPLE_W);
  localparam logic [CNT_W-1:0] SLOT_LEN = CNT_W'(SLOT_BITS);

  fmt_e             fmt_q;
  logic             primed, in_slot, have_left, lr_prev;
  ch_e              cur_ch, dsp_next, new_ch;
  logic [CNT_W-1:0] idx, idx_inc, delay, word_len, pos;
  logic             chg, cap, start_det;

  assign chg     = (fmt_sel != fmt_q);
  assign cap     = (fmt_sel == FMT_DSP) ? cap_fall : cap_rise;
  assign idx_inc = (idx == CNT_MAX) ? idx : idx + 1'b1;
  assign pos     = idx_inc - delay;
  assign wr_bit  = dat;

  always_comb begin
    case (fmt_sel)
      FMT_LJ:  delay = '0;
      FMT_RJ:  delay = SLOT_LEN - CNT_W'(rj_len_bits(rj_len));
      default: delay = CNT_W'(1);
    endcase
    word_len = (fmt_sel == FMT_RJ) ? CNT_W'(rj_len_bits(rj_len)) : FULL_LEN;
  end

  always_comb begin
    case (fmt_sel)
      FMT_I2S: new_ch = lr ? CH_R : CH_L;
      FMT_DSP: new_ch = dsp_next;
      default: new_ch = lr ? CH_L : CH_R;
    endcase
    if (fmt_sel == FMT_DSP) start_det = primed & lr & ~lr_prev;
    else                    start_det = primed & (lr ^ lr_prev);
  end

  always_comb begin
    wr_en  = 1'b0;
    wr_ch  = cur_ch;
    wr_pos = '0;
    clr_en = 1'b0;
    clr_ch = new_ch;
    emit   = 1'b0;
    if (cap && !chg) begin
      if (start_det) begin
        clr_en = 1'b1;
        if (delay == CNT_W'(1)) begin
          // trailing bit of the slot that is closing
          if (in_slot && idx < word_len) begin
            wr_en  = 1'b1;
            wr_ch  = cur_ch;
            wr_pos = idx;
          end
        end else if (delay == '0) begin
          wr_en  = 1'b1;
          wr_ch  = new_ch;
          wr_pos = '0;
        end
        emit = in_slot && (cur_ch == CH_R) && (new_ch == CH_L) && have_left;
      end else if (in_slot) begin
        if (idx_inc >= delay && pos < word_len) begin
          wr_en  = 1'b1;
          wr_ch  = cur_ch;
          wr_pos = pos;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q     <= FMT_LJ;
      primed    <= 1'b0;
      lr_prev   <= 1'b0;
      in_slot   <= 1'b0;
      cur_ch    <= CH_L;
      idx       <= '0;
      have_left <= 1'b0;
      dsp_next  <= CH_L;
    end else begin
      fmt_q <= fmt_e'(fmt_sel);
      if (chg) begin
        primed    <= 1'b0;
        in_slot   <= 1'b0;
        have_left <= 1'b0;
        dsp_next  <= CH_L;
        idx       <= '0;
      end else if (cap) begin
        lr_prev <= lr;
        primed  <= 1'b1;
        if (start_det) begin
          in_slot  <= 1'b1;
          cur_ch   <= new_ch;
          idx      <= '0;
          dsp_next <= (new_ch == CH_L) ? CH_R : CH_L;
          if (new_ch == CH_L) have_left <= 1'b1;
        end else if (in_slot) begin
          idx <= idx_inc;
        end
      end
    end
  end

endmodule

// File: rtl/aud_rx_assembler.sv
module aud_rx_assembler
  import aud_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  ch_e                 wr_ch,
  input  logic [CNT_W-1:0]    wr_pos,
  input  logic                wr_bit,
  input  logic                clr_en,
  input  ch_e                 clr_ch,
  input  logic                emit,
  output logic [SAMPLE_W-1:0] left_sample,
  output logic [SAMPLE_W-1:0] right_sample,
  output logic                pair_valid
);

  localparam logic [CNT_W-1:0] TOP_BIT = CNT_W'(SAMPLE_W - 1);
  localparam int NUM_CH = 2;

  logic [SAMPLE_W-1:0] bit_mask;
  assign bit_mask = {{(SAMPLE_W-1){1'b0}}, 1'b1} << (TOP_BIT - wr_pos);

  genvar gc;
  generate
    for (gc = 0; gc < NUM_CH; gc++) begin : g_ch
      logic [SAMPLE_W-1:0] acc_q, acc_d;
      always_comb begin
        acc_d = acc_q;
        if (clr_en && clr_ch == ch_e'(gc)) acc_d = '0;
        if (wr_en && wr_ch == ch_e'(gc))
          acc_d = (acc_d & ~bit_mask) | (wr_bit ? bit_mask : '0);
      end
      always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_d;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      left_sample  <= '0;
      right_sample <= '0;
      pair_valid   <= 1'b0;
    end else begin
      pair_valid <= emit;
      if (emit) begin
        left_sample  <= g_ch[0].acc_q;
        right_sample <= g_ch[1].acc_d;
      end
    end
  end

endmodule

// File: rtl/aud_ser_rx.sv
module aud_ser_rx
  import aud_rx_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SLOT_BITS   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ser_bclk,
  input  logic                ser_lrclk,
  input  logic                ser_data,
  input  logic [1:0]          fmt_sel,
  input  logic [1:0]          rj_len,
  output logic [SAMPLE_W-1:0] left_sample,
  output logic [SAMPLE_W-1:0] right_sample,
  output logic                pair_valid
);

  localparam int CNT_W = $clog2(SLOT_BITS) + 1;

  logic [2:0]       s_lines;
  logic             bclk_rise, bclk_fall;
  logic             wr_en, wr_bit, clr_en, emit_w;
  ch_e              wr_ch, clr_ch;
  logic [CNT_W-1:0] wr_pos;

  aud_rx_sync #(.W(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst),
    .async_in({ser_data, ser_lrclk, ser_bclk}),
    .sync_out(s_lines)
  );

  aud_rx_edge edge_i (
    .clk(clk), .rst(rst), .lvl(s_lines[0]),
    .rise(bclk_rise), .fall(bclk_fall)
  );

  aud_rx_framer #(.SAMPLE_W(SAMPLE_W), .SLOT_BITS(SLOT_BITS), .CNT_W(CNT_W)) framer_i (
    .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .rj_len(rj_len),
    .cap_rise(bclk_rise), .cap_fall(bclk_fall),
    .lr(s_lines[1]), .dat(s_lines[2]),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_pos(wr_pos), .wr_bit(wr_bit),
    .clr_en(clr_en), .clr_ch(clr_ch), .emit(emit_w)
  );

  aud_rx_assembler #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) asm_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_pos(wr_pos), .wr_bit(wr_bit),
    .clr_en(clr_en), .clr_ch(clr_ch), .emit(emit_w),
    .left_sample(left_sample), .right_sample(right_sample),
    .pair_valid(pair_valid)
  );

endmodule

// File: rtl/aud_ser_rx_chk.sv
module aud_ser_rx_chk #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          fmt_sel,
  input logic [1:0]          rj_len,
  input logic                emit,
  input logic                bclk_rise,
  input logic                bclk_fall,
  input logic [SAMPLE_W-1:0] left_sample,
  input logic [SAMPLE_W-1:0] right_sample,
  input logic                pair_valid
);

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (rst)
    pair_valid |=> !pair_valid);

  assert_emit_to_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    emit |=> pair_valid);

  assert_hold_outputs_R9: assert property (@(posedge clk) disable iff (rst)
    !pair_valid |-> ($stable(left_sample) && $stable(right_sample)));

  assert_fmt_change_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (fmt_sel != $past(fmt_sel)) |=> !pair_valid);

  assert_dsp_fall_edge_R5: assert property (@(posedge clk) disable iff (rst)
    (emit && fmt_sel == 2'b11) |-> bclk_fall);

  assert_rise_edge_R2: assert property (@(posedge clk) disable iff (rst)
    (emit && fmt_sel != 2'b11) |-> bclk_rise);

  assert_rj16_zero_fill_R6: assert property (@(posedge clk) disable iff (rst)
    (pair_valid && $past(fmt_sel) == 2'b10 && $past(rj_len) == 2'b10)
      |-> (left_sample[SAMPLE_W-17:0] == '0 && right_sample[SAMPLE_W-17:0] == '0));

endmodule

bind aud_ser_rx aud_ser_rx_chk #(.SAMPLE_W(SAMPLE_W)) chk_i (
  .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .rj_len(rj_len),
  .emit(emit_w), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
  .left_sample(left_sample), .right_sample(right_sample),
  .pair_valid(pair_valid)
);

// File: tb/aud_ser_rx_tb_top.sv
module aud_ser_rx_tb_top;

  localparam int NB = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_bclk = 1'b0, ser_lrclk = 1'b0, ser_data = 1'b0;
  logic [1:0]  fmt_sel = 2'b00, rj_len = 2'b00;
  logic [23:0] left_sample, right_sample;
  logic        pair_valid;

  int checks = 0;
  int fails  = 0;

  aud_ser_rx dut_i (
    .clk(clk), .rst(rst), .ser_bclk(ser_bclk), .ser_lrclk(ser_lrclk),
    .ser_data(ser_data), .fmt_sel(fmt_sel), .rj_len(rj_len),
    .left_sample(left_sample), .right_sample(right_sample),
    .pair_valid(pair_valid)
  );

  always #10 clk = ~clk;

  // strobe monitor, sampled away from the active edge
  int          vtotal = 0, run = 0, max_run = 0;
  logic [23:0] cap_l [0:63];
  logic [23:0] cap_r [0:63];
  always @(negedge clk) begin
    if (!rst && pair_valid) begin
      cap_l[vtotal % 64] <= left_sample;
      cap_r[vtotal % 64] <= right_sample;
      vtotal <= vtotal + 1;
      run <= run + 1;
      if (run + 1 > max_run) max_run <= run + 1;
    end else begin
      run <= 0;
    end
  end

  bit lr_a [0:NB-1];
  bit d_a  [0:NB-1];
  int nb;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] expw(input logic [31:0] w, input int n);
    if (n >= 24) return 24'(w >> (n - 24));
    return 24'(w << (24 - n));
  endfunction

  task automatic clear_stream();
    for (int i = 0; i < NB; i++) begin lr_a[i] = 1'b0; d_a[i] = 1'b0; end
    nb = 0;
  endtask

  task automatic push_idle(input bit lvl, input int n);
    for (int k = 0; k < n; k++) lr_a[nb + k] = lvl;
    nb += n;
  endtask

  task automatic push_slot(input bit lvl, input bit pulse, input logic [31:0] w,
                           input int nbits, input int dly, input int slot);
    for (int k = 0; k < slot; k++) lr_a[nb + k] = pulse ? (k == 0) : lvl;
    for (int p = 0; p < nbits; p++) d_a[nb + dly + p] = w[nbits - 1 - p];
    nb += slot;
  endtask

  task automatic play(input bit fall_cap);
    for (int i = 0; i < nb; i++) begin
      ser_bclk  = fall_cap;
      ser_lrclk = lr_a[i];
      ser_data  = d_a[i];
      repeat (4) @(negedge clk);
      ser_bclk = ~fall_cap;
      repeat (4) @(negedge clk);
    end
    repeat (10) @(negedge clk);
  endtask

  task automatic set_mode(input logic [1:0] m);
    fmt_sel = m ^ 2'b01;
    repeat (3) @(negedge clk);
    fmt_sel = m;
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_pair(input string req, input int base, input int k,
                             input logic [23:0] el, input logic [23:0] er);
    chk(req, "left word", 32'(cap_l[(base + k) % 64]), 32'(el));
    chk(req, "right word", 32'(cap_r[(base + k) % 64]), 32'(er));
  endtask

  task automatic t_reset();
    chk("R1", "left after reset", 32'(left_sample), 32'h0);
    chk("R1", "right after reset", 32'(right_sample), 32'h0);
    chk("R1", "strobe after reset", 32'(pair_valid), 32'h0);
  endtask

  // R2 and R8: stream opens with an orphan right slot, one full pair follows
  task automatic t_lj_basic();
    int base;
    set_mode(2'b00); clear_stream(); base = vtotal;
    push_idle(1'b1, 3);
    push_slot(1'b0, 1'b0, 32'h0F0F0F, 24, 0, 32);
    push_slot(1'b1, 1'b0, 32'h123456, 24, 0, 32);
    push_slot(1'b0, 1'b0, 32'hABCDEF, 24, 0, 32);
    push_slot(1'b1, 1'b0, 32'h0, 0, 0, 6);
    play(1'b0);
    chk("R8", "strobes for one full pair", 32'(vtotal - base), 32'd1);
    expect_pair("R2", base, 0, 24'h123456, 24'hABCDEF);
  endtask

  task automatic t_lj_short();
    int base;
    set_mode(2'b00); clear_stream(); base = vtotal;
    push_idle(1'b0, 3);
    push_slot(1'b1, 1'b0, 32'h8001, 16, 0, 32);
    push_slot(1'b0, 1'b0, 32'h7FFE, 16, 0, 32);
    push_slot(1'b1, 1'b0, 32'h0, 0, 0, 6);
    play(1'b0);
    chk("R6", "strobe count", 32'(vtotal - base), 32'd1);
    expect_pair("R6", base, 0, 24'h800100, 24'h7FFE00);
  endtask

  task automatic t_lj_long();
    int base;
    set_mode(2'b00); clear_stream(); base = vtotal;
    push_idle(1'b0, 3);
    push_slot(1'b1, 1'b0, 32'hFEDCBA9, 28, 0, 32);
    push_slot(1'b0, 1'b0, 32'h1234567, 28, 0, 32);
    push_slot(1'b1, 1'b0, 32'h0, 0, 0, 6);
    play(1'b0);
    chk("R7", "strobe count", 32'(vtotal - base), 32'd1);
    expect_pair("R7", base, 0, 24'hFEDCBA, 24'h123456);
  endtask

  task automatic t_i2s(input int slot, input logic [23:0] l, input logic [23:0] r);
    int base;
    set_mode(2'b01); clear_stream(); base = vtotal;
    push_idle(1'b1, 3);
    push_slot(1'b0, 1'b0, 32'(l), 24, 1, slot);
    push_slot(1'b1, 1'b0, 32'(r), 24, 1, slot);
    push_slot(1'b0, 1'b0, 32'h0, 0, 1, 6);
    play(1'b0);
    chk("R3", "strobe count", 32'(vtotal - base), 32'd1);
    expect_pair("R3", base, 0, l, r);
  endtask

  task automatic t_rj(input logic [1:0] code, input int n, input logic [31:0] l, input logic [31:0] r);
    int base;
    rj_len = code;
    set_mode(2'b10); clear_stream(); base = vtotal;
    push_idle(1'b0, 3);
    push_slot(1'b1, 1'b0, l, n, 32 - n, 32);
    push_slot(1'b0, 1'b0, r, n, 32 - n, 32);
    push_slot(1'b1, 1'b0, 32'h0, 0, 0, 6);
    play(1'b0);
    chk("R4", "strobe count", 32'(vtotal - base), 32'd1);
    expect_pair("R4", base, 0, expw(l, n), expw(r, n));
  endtask

  // R5: four pulses plus a closing pulse give two pairs in strict order
  task automatic t_dsp();
    int base;
    set_mode(2'b11); clear_stream(); base = vtotal;
    push_idle(1'b0, 3);
    push_slot(1'b0, 1'b1, 32'h2468AC, 24, 1, 32);
    push_slot(1'b0, 1'b1, 32'hFDB975, 24, 1, 32);
    push_slot(1'b0, 1'b1, 32'h0F1E2D, 24, 1, 32);
    push_slot(1'b0, 1'b1, 32'hF0E1D2, 24, 1, 32);
    push_slot(1'b0, 1'b1, 32'h0, 0, 1, 6);
    play(1'b1);
    chk("R5", "strobe count", 32'(vtotal - base), 32'd2);
    expect_pair("R5", base, 0, 24'h2468AC, 24'hFDB975);
    expect_pair("R5", base, 1, 24'h0F1E2D, 24'hF0E1D2);
  endtask

  task automatic t_dsp_short();
    int base;
    set_mode(2'b11); clear_stream(); base = vtotal;
    push_idle(1'b0, 2);
    push_slot(1'b0, 1'b1, 32'hA5A5, 16, 1, 20);
    push_slot(1'b0, 1'b1, 32'h5A5B, 16, 1, 20);
    push_slot(1'b0, 1'b1, 32'h0, 0, 1, 6);
    play(1'b1);
    chk("R5", "short strobe count", 32'(vtotal - base), 32'd1);
    expect_pair("R6", base, 0, 24'hA5A500, 24'h5A5B00);
  endtask

  // R10 and R9: a pair cut by a format change yields nothing; outputs hold
  task automatic t_mode_change();
    int base;
    set_mode(2'b00); clear_stream(); base = vtotal;
    push_idle(1'b0, 3);
    push_slot(1'b1, 1'b0, 32'h777777, 24, 0, 32);
    push_slot(1'b0, 1'b0, 32'h666666, 24, 0, 32);
    play(1'b0);
    set_mode(2'b00);
    clear_stream();
    push_slot(1'b1, 1'b0, 32'h0, 0, 0, 8);
    play(1'b0);
    chk("R10", "no strobe across format change", 32'(vtotal - base), 32'd0);
    chk("R9", "left holds", 32'(left_sample), 32'hA5A500);
    chk("R9", "right holds", 32'(right_sample), 32'h5A5B00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    t_lj_basic();
    t_lj_short();
    t_lj_long();
    t_i2s(32, 24'h5A5A5A, 24'hC3C3C3);
    t_i2s(24, 24'h800001, 24'hFFFFFF);
    t_rj(2'b00, 24, 32'h9ABCDE, 32'h13579B);
    t_rj(2'b01, 20, 32'hFEDCB, 32'h80001);
    t_rj(2'b10, 16, 32'hBEEF, 32'h0102);
    t_rj(2'b11, 24, 32'h3C5A96, 32'hC3A569);
    t_dsp();
    t_dsp_short();
    t_mode_change();
    chk("R8", "longest strobe run", 32'(max_run), 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule